// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block stands between the bus write path and the non-volatile array of a byte-wide memory. Every write request it sees carries an address and a data byte. Array writes stay blocked until three command writes arrive in the right order, each with a fixed address and data value. Once all three have been seen, the byte or page writes that follow are qualified for the array. The key writes themselves are marked as consumed and never go to the array.

The page-write timer gives a byte-load timeout pulse when no write has come within the load window. A programming-start pulse marks the start of the internal programming cycle. Either pulse drops the detector back to its locked idle stage, so every new write session must present the key again. Each write strobe gets exactly one verdict in the cycle it arrives: passed to the array, consumed by the key, or rejected.

Top module: `wpk_unlock`

## Requirements
- R1: While reset is held and right after it is released, `key_stage` is 0 and `arr_wr_ok`, `key_take` and `key_miss` are all low.
- R2: `key_stage` encodes the progress: 0 = locked idle, 1 = first key write seen, 2 = second key write seen, 3 = unlocked. A write of data 0xAA to address 0x5555 in stage 0, 0x55 to 0x2AAA in stage 1, or 0xA0 to 0x5555 in stage 2 raises `key_take` in its strobe cycle and moves the stage up by one on the next edge.
- R3: In stages 0 to 2, a write that does not equal the step expected in that stage raises `key_miss` and returns the stage to 0. This includes a write that equals a different step of the key.
- R4: In stage 3 every write raises `arr_wr_ok` and leaves the stage at 3. This includes writes whose address and data equal a key step.
- R5: Every strobe raises exactly one of `arr_wr_ok`, `key_take` and `key_miss` in the same cycle. Without a strobe all three stay low.
- R6: A `load_timeout` pulse returns the stage to 0 on the next edge, whatever the stage.
- R7: A `prog_start` pulse returns the stage to 0 on the next edge, whatever the stage, including the unlocked stage.
- R8: A strobe in the same cycle as `load_timeout` or `prog_start` is rejected with `key_miss`, even if it matches the expected key step or the stage is 3, and the stage goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_strobe | input | 1 | One-cycle pulse per bus write request |
| wr_addr | input | ADDR_W (15) | Address of the write request |
| wr_data | input | DATA_W (8) | Data byte of the write request |
| load_timeout | input | 1 | Byte-load window expired, from the page-write timer |
| prog_start | input | 1 | Internal programming cycle begins |
| arr_wr_ok | output | 1 | This strobe's write may be loaded into the array |
| key_take | output | 1 | This strobe was consumed as a key step |
| key_miss | output | 1 | This strobe was rejected |
| key_stage | output | 2 | Sequence progress, 0 locked to 3 unlocked |

## Verification
From each of the three locked stages, the bench applies six write patterns: the three true key steps, right address with wrong data, wrong address with right data, and an unrelated address. This separates a correct match of the expected step from a match of any key step, and an address-only or data-only compare from a full compare. In the unlocked stage it applies data writes and key-shaped writes, which shows that the unlocked stage passes writes and does not decode the key again. It sends timeout and programming-start pulses in every stage, alone and together with a strobe. This shows that these pulses win over a match and over the unlocked stage.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GOT1 = 2'd1,
    ST_GOT2 = 2'd2,
    ST_OPEN = 2'd3
  } wpk_stage_e;

  localparam int KEY_STEPS = 3;

  // Key table: step order is the behaviour, index 0 is expected first
  localparam logic [15:0] KEY_ADDR [KEY_STEPS] = '{16'h5555, 16'h2AAA, 16'h5555};
  localparam logic [7:0]  KEY_DATA [KEY_STEPS] = '{8'hAA, 8'h55, 8'hA0};

endpackage

// File: rtl/wpk_rst_sync.sv
module wpk_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/wpk_key_match.sv
module wpk_key_match
  import wpk_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    data,
  output logic [KEY_STEPS-1:0] step_hit
);

  // One full address and data comparator per key step
  for (genvar g = 0; g < KEY_STEPS; g++) begin : g_step
    logic addr_eq;
    logic data_eq;
    assign addr_eq     = (addr == ADDR_W'(KEY_ADDR[g]));
    assign data_eq     = (data == DATA_W'(KEY_DATA[g]));
    assign step_hit[g] = addr_eq && data_eq;
  end

endmodule

// File: rtl/wpk_seq_fsm.sv
module wpk_seq_fsm
  import wpk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_strobe,
  input  logic                 abort_req,
  input  logic [KEY_STEPS-1:0] step_hit,
  output wpk_stage_e           stage,
  output logic                 take,
  output logic                 miss,
  output logic                 pass
);

  wpk_stage_e stage_q;
  wpk_stage_e stage_d;
  logic       stage_en;
  logic       exp_hit;
  logic       locked;

  // Select the comparator for the step expected in this stage
  always_comb begin
    case (stage_q)
      ST_IDLE: exp_hit = step_hit[0];
      ST_GOT1: exp_hit = step_hit[1];
      ST_GOT2: exp_hit = step_hit[2];
      default: exp_hit = 1'b0;
    endcase
  end

  assign locked = (stage_q != ST_OPEN);

  // Per-strobe verdict, exactly one when a strobe is present
  always_comb begin
    take = 1'b0;
    miss = 1'b0;
    pass = 1'b0;
    if (wr_strobe) begin
      if (abort_req) begin
        miss = 1'b1;
      end else if (!locked) begin
        pass = 1'b1;
      end else if (exp_hit) begin
        take = 1'b1;
      end else begin
        miss = 1'b1;
      end
    end
  end

  // Next stage
  always_comb begin
    stage_d = stage_q;
    if (abort_req) begin
      stage_d = ST_IDLE;
    end else if (wr_strobe && locked) begin
      if (exp_hit) begin
        case (stage_q)
          ST_IDLE: stage_d = ST_GOT1;
          ST_GOT1: stage_d = ST_GOT2;
          default: stage_d = ST_OPEN;
        endcase
      end else begin
        stage_d = ST_IDLE;
      end
    end
  end

  assign stage_en = abort_req || wr_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  assign stage = stage_q;

endmodule

// File: rtl/wpk_unlock.sv
module wpk_unlock
  import wpk_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_timeout,
  input  logic              prog_start,
  output logic              arr_wr_ok,
  output logic              key_take,
  output logic              key_miss,
  output logic [1:0]        key_stage
);

  logic                 rst_n_int;
  logic [KEY_STEPS-1:0] step_hit;
  logic                 abort_req;
  wpk_stage_e           stage;

  wpk_rst_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  wpk_key_match #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_key_match (
    .addr    (wr_addr),
    .data    (wr_data),
    .step_hit(step_hit)
  );

  assign abort_req = load_timeout || prog_start;

  wpk_seq_fsm u_seq_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_strobe(wr_strobe),
    .abort_req(abort_req),
    .step_hit (step_hit),
    .stage    (stage),
    .take     (key_take),
    .miss     (key_miss),
    .pass     (arr_wr_ok)
  );

  assign key_stage = stage;

endmodule

// File: rtl/wpk_unlock_chk.sv
module wpk_unlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_strobe,
  input logic       load_timeout,
  input logic       prog_start,
  input logic       arr_wr_ok,
  input logic       key_take,
  input logic       key_miss,
  input logic [1:0] key_stage
);

  AST_TAKE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    key_take |=> (key_stage == $past(key_stage) + 2'd1)); // R2

  AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_miss |=> (key_stage == 2'd0)); // R3

  AST_PASS_HOLDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |=> (key_stage == 2'd3)); // R4

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($countones({arr_wr_ok, key_take, key_miss}) == 1)); // R5

  AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> !(arr_wr_ok || key_take || key_miss)); // R5

  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_timeout |=> (key_stage == 2'd0)); // R6

  AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> (key_stage == 2'd0)); // R7

  AST_ABORT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && (load_timeout || prog_start)) |-> key_miss); // R8

  AST_OPEN_VIA_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_stage == 2'd3) |-> $past(key_take)); // R2

endmodule

bind wpk_unlock wpk_unlock_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .wr_strobe   (wr_strobe),
  .load_timeout(load_timeout),
  .prog_start  (prog_start),
  .arr_wr_ok   (arr_wr_ok),
  .key_take    (key_take),
  .key_miss    (key_miss),
  .key_stage   (key_stage)
);

// File: tb/tb_wpk_unlock.sv
module tb_wpk_unlock;

  localparam int AW = 15;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          wr_strobe;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          load_timeout;
  logic          prog_start;
  logic          arr_wr_ok;
  logic          key_take;
  logic          key_miss;
  logic [1:0]    key_stage;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [AW-1:0] key_a [3];
  logic [DW-1:0] key_d [3];
  logic [AW-1:0] cand_a [6];
  logic [DW-1:0] cand_d [6];

  wpk_unlock dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_strobe   (wr_strobe),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .load_timeout(load_timeout),
    .prog_start  (prog_start),
    .arr_wr_ok   (arr_wr_ok),
    .key_take    (key_take),
    .key_miss    (key_miss),
    .key_stage   (key_stage)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, capture verdict, clear at next negedge
  task automatic bus(input logic s, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic to, input logic pg,
                     output logic ok, output logic tk, output logic ms);
    @(negedge clk);
    wr_strobe = s; wr_addr = a; wr_data = d; load_timeout = to; prog_start = pg;
    #1;
    ok = arr_wr_ok; tk = key_take; ms = key_miss;
    @(negedge clk);
    wr_strobe = 1'b0; load_timeout = 1'b0; prog_start = 1'b0;
    #1;
  endtask

  task automatic go_idle();
    logic ok, tk, ms;
    bus(1'b0, '0, '0, 1'b1, 1'b0, ok, tk, ms);
  endtask

  task automatic reach(input int s);
    logic ok, tk, ms;
    go_idle();
    for (int i = 0; i < s; i++) bus(1'b1, key_a[i], key_d[i], 1'b0, 1'b0, ok, tk, ms);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ok, tk, ms;
    key_a[0] = 15'h5555; key_d[0] = 8'hAA;
    key_a[1] = 15'h2AAA; key_d[1] = 8'h55;
    key_a[2] = 15'h5555; key_d[2] = 8'hA0;
    cand_a[0] = 15'h5555; cand_d[0] = 8'hAA;
    cand_a[1] = 15'h2AAA; cand_d[1] = 8'h55;
    cand_a[2] = 15'h5555; cand_d[2] = 8'hA0;
    cand_a[3] = 15'h5555; cand_d[3] = 8'h55;
    cand_a[4] = 15'h2AAA; cand_d[4] = 8'hAA;
    cand_a[5] = 15'h0123; cand_d[5] = 8'hA0;

    rst_n = 1'b0; wr_strobe = 1'b0; wr_addr = '0; wr_data = '0;
    load_timeout = 1'b0; prog_start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 stage in reset", int'(key_stage), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 stage after reset", int'(key_stage), 0);
    check("R1 flags after reset", int'({arr_wr_ok, key_take, key_miss}), 0);

    // Sweep every candidate in every locked stage (R2, R3, R5)
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 6; c++) begin
        bit m;
        reach(s);
        m = (cand_a[c] == key_a[s]) && (cand_d[c] == key_d[s]);
        bus(1'b1, cand_a[c], cand_d[c], 1'b0, 1'b0, ok, tk, ms);
        if (m) begin
          check("R2 take on key step", int'(tk), 1);
          check("R2 stage advance", int'(key_stage), s + 1);
        end else begin
          check("R3 miss on wrong step", int'(ms), 1);
          check("R3 stage back to idle", int'(key_stage), 0);
        end
        check("R5 one verdict locked", int'(ok) + int'(tk) + int'(ms), 1);
        check("R5 no pass while locked", int'(ok), 0);
      end
    end

    // Unlocked: data writes and key-shaped writes all pass (R4)
    reach(3);
    check("R2 unlocked stage", int'(key_stage), 3);
    for (int c = 0; c < 6; c++) begin
      bus(1'b1, cand_a[c] ^ AW'(c * 7), cand_d[c], 1'b0, 1'b0, ok, tk, ms);
      check("R4 pass when open", int'(ok), 1);
      check("R5 only pass when open", int'(tk) + int'(ms), 0);
      check("R4 stays open", int'(key_stage), 3);
    end

    // No strobe: no verdict (R5)
    @(negedge clk); #1;
    check("R5 quiet without strobe", int'({arr_wr_ok, key_take, key_miss}), 0);

    // Timeout and programming start from every stage (R6, R7)
    for (int s = 0; s < 4; s++) begin
      reach(s);
      check("R2 reached stage", int'(key_stage), s);
      bus(1'b0, '0, '0, 1'b1, 1'b0, ok, tk, ms);
      check("R6 timeout clears", int'(key_stage), 0);
      reach(s);
      bus(1'b0, '0, '0, 1'b0, 1'b1, ok, tk, ms);
      check("R7 prog start clears", int'(key_stage), 0);
    end

    // Strobe together with abort (R8)
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = (s < 3) ? key_a[s] : 15'h0040;
      d = (s < 3) ? key_d[s] : 8'h3C;
      reach(s);
      bus(1'b1, a, d, (s % 2) == 0, (s % 2) == 1, ok, tk, ms);
      check("R8 miss with abort", int'(ms), 1);
      check("R8 no take or pass", int'(ok) + int'(tk), 0);
      check("R8 stage idle", int'(key_stage), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule